// File: doc/BRIEF.md
# Multi-channel ADC Sample Formatter

This block sits between four converter channels and the serial output stage. Each channel delivers a signed conversion result that is a little wider than the output word. The block clamps that result to the 14-bit range and produces an offset binary code. It can then turn the code into two's complement and can scramble it by folding the least significant bit into the upper bits. The result goes into one register per channel. All four channels share a single set of mode inputs, so they are always formatted the same way.

A test-pattern mode replaces every channel's word with one programmed value, whatever the other modes are set to. An output-disable input forces all data to zero and drops an enable flag that stands in for the pad drivers. A separate combinational decoder is included for the receive side. It undoes the scrambling, so a link partner or a loopback test can recover the original code.

Every mode input is sampled on the same clock edge as the data. A change to a mode applies to the sample taken at the next rising edge, and one sample is never built from a mix of old and new settings. The latency is one clock in every mode.

Top module: `adc_fmt_top`

## Requirements
- R1: While reset is asserted, every data output bit is 0 and `out_en` is 0.
- R2: With all modes off, one clock after a sample is presented, the channel output is the input plus 8192, written as an unsigned 14-bit code. Input 0 gives 0x2000, input -8192 gives 0x0000 and input 8191 gives 0x3FFF.
- R3: Inputs above 8191 clamp to the full-scale positive code, and inputs below -8192 clamp to the full-scale negative code. The outputs never wrap.
- R4: With `cfg_twos` set, the output is the offset binary code with bit 13 inverted. Input 0 gives 0x0000, positive full scale gives 0x1FFF and negative full scale gives 0x2000.
- R5: With `cfg_rand` set, output bits 13..1 each equal the coded bit XOR the coded bit 0, and output bit 0 equals the coded bit 0. Scrambling is applied after the coding choice.
- R6: With `cfg_tp_en` set, every channel outputs `cfg_tp_val` one clock later. `cfg_twos` and `cfg_rand` have no effect on that output.
- R7: With `cfg_out_dis` set, all data outputs are 0 and `out_en` is 0 one clock later. This overrides test-pattern mode. With `cfg_out_dis` clear, `out_en` is 1 one clock later.
- R8: With `dec_rand_en` set, `dec_out` is `dec_in` with bit 0 XORed into bits 13..1. With it clear, `dec_out` equals `dec_in`. Scrambling followed by this decoding returns the original code for all 16384 codes.
- R9: Channel k takes its input from `raw_in[16k+15:16k]` and drives `data_out[14k+13:14k]`, independently of the other channels.
- R10: A mode change presented with a sample applies to exactly that sample, one clock later, for every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_in | input | 64 | Four signed 16-bit conversion results, channel 0 in the low bits |
| cfg_twos | input | 1 | Select two's complement coding |
| cfg_rand | input | 1 | Enable LSB scrambling |
| cfg_tp_en | input | 1 | Replace all channel data with the test pattern |
| cfg_tp_val | input | 14 | Test-pattern value |
| cfg_out_dis | input | 1 | Force data to zero and drop the enable flag |
| data_out | output | 56 | Four registered 14-bit output words, channel 0 in the low bits |
| out_en | output | 1 | High when the outputs are driven |
| dec_in | input | 14 | Received word for the receive-side decoder |
| dec_rand_en | input | 1 | Decoder removes scrambling when set |
| dec_out | output | 14 | Decoded word |

## Verification
The bench builds the block with its default parameters: four channels, 14-bit words and 2 guard bits. At this size every one of the 16384 in-range codes can be driven through all four combinations of coding and scrambling. Each channel gets a different rotation of the sweep. Every registered output is looped back through the decoder, which proves the encode-decode identity for every code with scrambling both on and off. The 2 guard bits let the bench drive values well past both ends of the range, up to the extremes of the 16-bit input, to exercise the clamps.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef struct packed {
    logic twos;
    logic rand_en;
    logic tp_en;
    logic dis;
  } fmt_mode_t;

endpackage

// File: rtl/adc_fmt_lane.sv
module adc_fmt_lane
  import adc_fmt_pkg::*;
#(
  parameter int W    = 14,
  parameter int IN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] raw,
  input  fmt_mode_t              mode,
  input  logic        [W-1:0]    tp_val,
  output logic        [W-1:0]    q,
  output logic                   sat_hi,
  output logic                   sat_lo
);

  localparam int GUARD = IN_W - W;
  localparam logic signed [IN_W-1:0] HI_LIM = {{(GUARD+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO_LIM = {{(GUARD+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  // clamp then add half scale (flipping the MSB of the low W bits)
  function automatic logic [W-1:0] clamp_to_ob(input logic signed [IN_W-1:0] v);
    if (v > HI_LIM)      return {W{1'b1}};
    else if (v < LO_LIM) return {W{1'b0}};
    else                 return v[W-1:0] ^ MSB_MASK;
  endfunction

  function automatic logic [W-1:0] ob_to_tc(input logic [W-1:0] c);
    return c ^ MSB_MASK;
  endfunction

  function automatic logic [W-1:0] lsb_fold(input logic [W-1:0] c);
    return c ^ {{(W-1){c[0]}}, 1'b0};
  endfunction

  logic [W-1:0] ob_code, coded, mixed, picked, nxt;

  always_comb begin
    sat_hi  = raw > HI_LIM;
    sat_lo  = raw < LO_LIM;
    ob_code = clamp_to_ob(raw);
    coded   = mode.twos    ? ob_to_tc(ob_code) : ob_code;
    mixed   = mode.rand_en ? lsb_fold(coded)   : coded;
    picked  = mode.tp_en   ? tp_val            : mixed;
    nxt     = mode.dis     ? '0                : picked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/adc_fmt_derand.sv
module adc_fmt_derand #(
  parameter int W = 14
) (
  input  logic [W-1:0] word_in,
  input  logic         en,
  output logic [W-1:0] word_out
);

  function automatic logic [W-1:0] lsb_unfold(input logic [W-1:0] c);
    return c ^ {{(W-1){c[0]}}, 1'b0};
  endfunction

  always_comb word_out = en ? lsb_unfold(word_in) : word_in;

endmodule

// File: rtl/adc_fmt_top.sv
module adc_fmt_top
  import adc_fmt_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int W       = 14,
  parameter int GUARD_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH*(W+GUARD_W)-1:0] raw_in,
  input  logic                       cfg_twos,
  input  logic                       cfg_rand,
  input  logic                       cfg_tp_en,
  input  logic [W-1:0]               cfg_tp_val,
  input  logic                       cfg_out_dis,
  output logic [NUM_CH*W-1:0]        data_out,
  output logic                       out_en,
  input  logic [W-1:0]               dec_in,
  input  logic                       dec_rand_en,
  output logic [W-1:0]               dec_out
);

  localparam int IN_W = W + GUARD_W;

  fmt_mode_t          mode;
  logic [NUM_CH-1:0]  sat_hi_w;
  logic [NUM_CH-1:0]  sat_lo_w;

  always_comb begin
    mode.twos    = cfg_twos;
    mode.rand_en = cfg_rand;
    mode.tp_en   = cfg_tp_en;
    mode.dis     = cfg_out_dis;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    adc_fmt_lane #(.W(W), .IN_W(IN_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw_in[ch*IN_W +: IN_W]),
      .mode   (mode),
      .tp_val (cfg_tp_val),
      .q      (data_out[ch*W +: W]),
      .sat_hi (sat_hi_w[ch]),
      .sat_lo (sat_lo_w[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_en <= 1'b0;
    else        out_en <= ~cfg_out_dis;
  end

  adc_fmt_derand #(.W(W)) u_dec (
    .word_in  (dec_in),
    .en       (dec_rand_en),
    .word_out (dec_out)
  );

endmodule

// File: rtl/adc_fmt_chk.sv
module adc_fmt_chk #(
  parameter int NUM_CH = 4,
  parameter int W      = 14,
  parameter int IN_W   = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH*IN_W-1:0] raw_in,
  input logic                   cfg_twos,
  input logic                   cfg_rand,
  input logic                   cfg_tp_en,
  input logic [W-1:0]           cfg_tp_val,
  input logic                   cfg_out_dis,
  input logic [NUM_CH*W-1:0]    data_out,
  input logic                   out_en,
  input logic [W-1:0]           dec_in,
  input logic                   dec_rand_en,
  input logic [W-1:0]           dec_out,
  input logic [NUM_CH-1:0]      sat_hi_w,
  input logic [NUM_CH-1:0]      sat_lo_w
);

  logic plain_path;
  assign plain_path = !cfg_out_dis && !cfg_tp_en && !cfg_rand;

  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out_dis |=> (data_out == '0) && !out_en);

  p_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_out_dis |=> out_en);

  p_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tp_en && !cfg_out_dis) |=> data_out == {NUM_CH{$past(cfg_tp_val)}});

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_path && !cfg_twos && sat_hi_w[0]) |=> data_out[W-1:0] == {W{1'b1}});

  p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_path && cfg_twos && sat_lo_w[0]) |=> data_out[W-1:0] == {1'b1, {(W-1){1'b0}}});

  p_zero_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_path && cfg_twos && raw_in[IN_W-1:0] == '0) |=> data_out[W-1:0] == '0);

  p_zero_ob_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_path && !cfg_twos && raw_in[IN_W-1:0] == '0)
      |=> data_out[W-1:0] == {1'b1, {(W-1){1'b0}}});

  always_comb begin
    if (dec_rand_en) begin
      p_dec_lsb_r8: assert (dec_out[0] == dec_in[0]);
    end else begin
      p_dec_pass_r8: assert (dec_out == dec_in);
    end
  end

endmodule

bind adc_fmt_top adc_fmt_chk #(.NUM_CH(NUM_CH), .W(W), .IN_W(W + GUARD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .raw_in      (raw_in),
  .cfg_twos    (cfg_twos),
  .cfg_rand    (cfg_rand),
  .cfg_tp_en   (cfg_tp_en),
  .cfg_tp_val  (cfg_tp_val),
  .cfg_out_dis (cfg_out_dis),
  .data_out    (data_out),
  .out_en      (out_en),
  .dec_in      (dec_in),
  .dec_rand_en (dec_rand_en),
  .dec_out     (dec_out),
  .sat_hi_w    (sat_hi_w),
  .sat_lo_w    (sat_lo_w)
);

// File: tb/tb_adc_fmt_top.sv
module tb_adc_fmt_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] raw_in = '0;
  logic        cfg_twos = 1'b0, cfg_rand = 1'b0, cfg_tp_en = 1'b0, cfg_out_dis = 1'b0;
  logic [13:0] cfg_tp_val = '0;
  logic [55:0] data_out;
  logic        out_en;
  logic [13:0] dec_in = '0;
  logic        dec_rand_en = 1'b0;
  logic [13:0] dec_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_fmt_top dut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in),
    .cfg_twos(cfg_twos), .cfg_rand(cfg_rand), .cfg_tp_en(cfg_tp_en),
    .cfg_tp_val(cfg_tp_val), .cfg_out_dis(cfg_out_dis),
    .data_out(data_out), .out_en(out_en),
    .dec_in(dec_in), .dec_rand_en(dec_rand_en), .dec_out(dec_out)
  );

  // coded word before scrambling, computed arithmetically
  function automatic int coded_val(input int v, input bit tc);
    int c;
    if (v > 8191) c = 16383;
    else if (v < -8192) c = 0;
    else c = v + 8192;
    if (tc) c = (c + 8192) % 16384;
    return c;
  endfunction

  function automatic int scram(input int c, input bit rnd);
    if (rnd && (c % 2 == 1)) return 16383 - c + 1;
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // present one sample per channel plus modes, then check after the edge
  task automatic step(input int v0, input int v1, input int v2, input int v3,
                      input bit tc, input bit rnd, input string req);
    int vals[4];
    logic [55:0] exp;
    vals[0] = v0; vals[1] = v1; vals[2] = v2; vals[3] = v3;
    @(negedge clk);
    cfg_twos = tc; cfg_rand = rnd; cfg_tp_en = 1'b0; cfg_out_dis = 1'b0;
    for (int k = 0; k < NCH; k++) raw_in[k*16 +: 16] = 16'(vals[k]);
    for (int k = 0; k < NCH; k++) exp[k*14 +: 14] = 14'(scram(coded_val(vals[k], tc), rnd));
    @(posedge clk); #1;
    check(req, {8'd0, data_out}, {8'd0, exp});
  endtask

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2 + 1);
    check("R1", {63'd0, out_en}, 64'd0);
    check("R1", {8'd0, data_out}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 reference points
    step(0, -8192, 8191, 1, 0, 0, "R2");
    @(negedge clk);
    check("R7 enable", {63'd0, out_en}, 64'd1);
    // R3 clamps, both codings
    step(8192, -8193, 32767, -32768, 0, 0, "R3");
    step(8192, -8193, 32767, -32768, 1, 0, "R3");
    // R4 two's complement reference points
    step(0, 8191, -8192, -1, 1, 0, "R4");
    // R9 independent channels
    step(100, -200, 3000, -4000, 0, 1, "R9");

    // full sweep: every code in all four modes, with decoder loopback (R5 R8)
    for (int m = 0; m < 4; m++) begin
      for (int code = 0; code < 16384; code++) begin
        bit tc, rnd;
        tc = m[0]; rnd = m[1];
        step(((code) % 16384) - 8192, ((code + 1000) % 16384) - 8192,
             ((code + 5003) % 16384) - 8192, ((code + 12000) % 16384) - 8192,
             tc, rnd, rnd ? "R5" : (tc ? "R4" : "R2"));
        dec_in = data_out[13:0];
        dec_rand_en = rnd;
        #1;
        check("R8 roundtrip", {50'd0, dec_out}, 64'(coded_val(code - 8192, tc)));
      end
    end

    // R10 mode flips each sample
    step(5, 5, 5, 5, 1, 0, "R10");
    step(5, 5, 5, 5, 0, 1, "R10");
    step(5, 5, 5, 5, 1, 1, "R10");

    // R6 test pattern overrides twos and rand
    @(negedge clk);
    cfg_tp_en = 1'b1; cfg_tp_val = 14'h2A5B; cfg_twos = 1'b1; cfg_rand = 1'b1;
    @(posedge clk); #1;
    check("R6", {8'd0, data_out}, {8'd0, {4{14'h2A5B}}});
    @(negedge clk);
    cfg_tp_val = 14'h0001; cfg_twos = 1'b0;
    @(posedge clk); #1;
    check("R6", {8'd0, data_out}, {8'd0, {4{14'h0001}}});

    // R7 disable overrides pattern
    @(negedge clk);
    cfg_out_dis = 1'b1;
    @(posedge clk); #1;
    check("R7", {8'd0, data_out}, 64'd0);
    check("R7", {63'd0, out_en}, 64'd0);
    @(negedge clk);
    cfg_out_dis = 1'b0; cfg_tp_en = 1'b0;
    step(-1, -1, -1, -1, 0, 0, "R7 resume");

    // R8 decoder direct
    @(negedge clk);
    dec_in = 14'h0003; dec_rand_en = 1'b1; #1;
    check("R8", {50'd0, dec_out}, 64'h3FFD);
    dec_rand_en = 1'b0; #1;
    check("R8", {50'd0, dec_out}, 64'h0003);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule